// File: doc/BRIEF.md
# Sixteen-Line Prioritised Interrupt Controller

This block gathers sixteen interrupt request lines, keeps a pending bit and an enable bit for each of them, and presents one winning request at a time to a processor. Software reaches the state through a small register window: enable and pending bits are never written directly. Each has one address that sets bits and another that clears them, and a 0 in the written word leaves that line alone. Both addresses of a pair read back the same live state. Each line also carries a two-bit priority, kept in the upper two bits of a byte lane, four lines to a 32-bit word.

A rising edge on a request line marks it pending. Among lines that are both pending and enabled, the lowest priority value wins, and on a tie the lowest line number wins. The winner is presented as a vector number, which is the line number plus 16, together with a valid flag. When the processor takes the interrupt it pulses the acknowledge input, and this clears the pending bit of the line presented at that edge. Read data is combinational from the address. Writes take effect at the next rising clock edge.

Top module: `intc_top`

## Requirements
- R1: After reset, every enable bit, pending bit and priority field is 0, `intValid` is low and `intVector` is 0.
- R2: A write to 0x100 sets the enable of every line whose bit (bit n for line n, bits 15:0) is 1, and bits written 0 leave their line unchanged. Reads of 0x100 and 0x180 both return the enable state in bits 15:0, with 0 above.
- R3: A write to 0x180 clears the enable of every line whose bit is 1, and bits written 0 have no effect.
- R4: A write to 0x200 marks lines pending where the bit is 1, and a write to 0x280 clears pending where the bit is 1. Zeros have no effect, and both addresses read back the pending state in bits 15:0.
- R5: The word at 0x400+4k holds the priorities of lines 4k to 4k+3 in bits 7:6, 15:14, 23:22 and 31:30, in that order. All other bits read 0 and ignore writes.
- R6: A 0-to-1 transition on `irqLines[n]` sets pending bit n at the next edge. A line held high does not set pending again once it has been cleared.
- R7: Among lines that are pending and enabled, the one with the smallest priority value wins. Value 0 is the most urgent and value 3 the least.
- R8: Among winners with equal priority, the lowest line number is chosen.
- R9: While a winner exists, `intValid` is high and `intVector` is the line number plus 16. Otherwise `intValid` is low and `intVector` is 0.
- R10: `intAck` sampled high while `intValid` is high clears the pending bit of the presented line at that edge.
- R11: A rising request edge wins over a clear-pending write and over an acknowledge on the same edge, so the line stays pending.
- R12: A line that is pending but disabled is never presented. It is presented as soon as it is enabled while still pending.
- R13: Addresses outside the map read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for the register window |
| busAddr | input | 12 | Byte address for reads and writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqLines | input | 16 | Interrupt request lines, edge sensitive |
| intAck | input | 1 | Acknowledge of the presented interrupt |
| intValid | output | 1 | A pending and enabled request exists |
| intVector | output | 5 | Vector number of the winner (line + 16) |

## Verification
Arbitration is driven with three kinds of candidate set. The first has different priority values, which shows whether the value is compared at all. The second has equal values, which isolates the tie rule on line number. The third holds pending lines that are disabled, which shows whether masking happens before the choice is made. Request edges are applied alone, together with clear-pending writes, and together with acknowledges, to separate edge detection from the set and clear precedence. A long pseudo-random stretch mixes all register writes, line toggles and acknowledges, and compares against a behavioural model on every cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Register window byte offsets
  localparam logic [11:0] OFS_EN_SET   = 12'h100;
  localparam logic [11:0] OFS_EN_CLR   = 12'h180;
  localparam logic [11:0] OFS_PEND_SET = 12'h200;
  localparam logic [11:0] OFS_PEND_CLR = 12'h280;
  localparam logic [11:0] OFS_PRIO     = 12'h400;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_EN,
    RD_PEND,
    RD_PRIO
  } rdSel_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic       setEn;
    logic       clrEn;
    logic       setPend;
    logic       clrPend;
    logic       prioWr;
    logic [3:0] prioWord;
    rdSel_e     rdSel;
    logic [3:0] rdWord;
  } strobes_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 4
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb
);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (busAddr == ADDR_W'(OFS_EN_SET)) begin
      strb.rdSel = RD_EN;
      strb.setEn = busWr;
    end else if (busAddr == ADDR_W'(OFS_EN_CLR)) begin
      strb.rdSel = RD_EN;
      strb.clrEn = busWr;
    end else if (busAddr == ADDR_W'(OFS_PEND_SET)) begin
      strb.rdSel   = RD_PEND;
      strb.setPend = busWr;
    end else if (busAddr == ADDR_W'(OFS_PEND_CLR)) begin
      strb.rdSel   = RD_PEND;
      strb.clrPend = busWr;
    end
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (busAddr == ADDR_W'(OFS_PRIO) + ADDR_W'(4 * w)) begin
        strb.rdSel    = RD_PRIO;
        strb.rdWord   = 4'(w);
        strb.prioWr   = busWr;
        strb.prioWord = 4'(w);
      end
    end
  end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_LINES = 16,
  parameter int PRIO_BITS = 2,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]           active,
  input  logic [NUM_LINES*PRIO_BITS-1:0] prioFlat,
  output logic                           found,
  output logic [IDX_W-1:0]               idx
);

  logic [PRIO_BITS-1:0] best;

  // Strict less-than keeps the lower line on a tie
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (active[i] && (!found || prioFlat[i*PRIO_BITS +: PRIO_BITS] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prioFlat[i*PRIO_BITS +: PRIO_BITS];
      end
    end
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PRIO_BITS = 2,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 intAck,
  output logic [DATA_W-1:0]    rdData,
  output logic                 winValid,
  output logic [IDX_W-1:0]     winIdx,
  output logic [NUM_LINES-1:0] enQ,
  output logic [NUM_LINES-1:0] pendQ
);

  localparam int LANE_W   = 8;
  localparam int LANES    = DATA_W / LANE_W;
  localparam int LANE_OFS = LANE_W - PRIO_BITS;

  logic [NUM_LINES-1:0]           irqPrev;
  logic [NUM_LINES-1:0]           rise;
  logic [NUM_LINES-1:0]           enD;
  logic [NUM_LINES-1:0]           pendD;
  logic [NUM_LINES-1:0]           ackMask;
  logic [NUM_LINES-1:0]           wrBits;
  logic [PRIO_BITS-1:0]           prioQ [NUM_LINES];
  logic [NUM_LINES*PRIO_BITS-1:0] prioFlat;
  logic                           unusedWr;

  assign wrBits   = wrData[NUM_LINES-1:0];
  assign unusedWr = ^wrData;
  assign rise     = irqLines & ~irqPrev;
  assign ackMask  = (intAck && winValid) ? (NUM_LINES'(1) << winIdx) : '0;

  always_comb begin
    enD = enQ;
    if (strb.setEn) enD = enD | wrBits;
    if (strb.clrEn) enD = enD & ~wrBits;
  end

  // Precedence, lowest to highest: ack, software clear, software set, hardware edge
  always_comb begin
    pendD = pendQ & ~ackMask;
    if (strb.clrPend) pendD = pendD & ~wrBits;
    if (strb.setPend) pendD = pendD | wrBits;
    pendD = pendD | rise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev <= '0;
      enQ     <= '0;
      pendQ   <= '0;
    end else begin
      irqPrev <= irqLines;
      enQ     <= enD;
      pendQ   <= pendD;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gPrio
    localparam int WORD = g / LANES;
    localparam int POS  = (g % LANES) * LANE_W + LANE_OFS;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioQ[g] <= '0;
      end else if (strb.prioWr && strb.prioWord == 4'(WORD)) begin
        prioQ[g] <= wrData[POS +: PRIO_BITS];
      end
    end
    assign prioFlat[g*PRIO_BITS +: PRIO_BITS] = prioQ[g];
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_EN:   rdData[NUM_LINES-1:0] = enQ;
      RD_PEND: rdData[NUM_LINES-1:0] = pendQ;
      RD_PRIO: begin
        for (int l = 0; l < NUM_LINES; l++) begin
          if (l / LANES == int'(strb.rdWord)) begin
            rdData[(l % LANES)*LANE_W + LANE_OFS +: PRIO_BITS] = prioQ[l];
          end
        end
      end
      default: rdData = '0;
    endcase
  end

  intc_arbiter #(
    .NUM_LINES(NUM_LINES),
    .PRIO_BITS(PRIO_BITS),
    .IDX_W    (IDX_W)
  ) uArb (
    .active  (pendQ & enQ),
    .prioFlat(prioFlat),
    .found   (winValid),
    .idx     (winIdx)
  );

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PRIO_BITS = 2,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int VEC_BASE  = 16,
  parameter int IDX_W     = $clog2(NUM_LINES),
  parameter int VEC_W     = $clog2(VEC_BASE + NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 intAck,
  output logic                 intValid,
  output logic [VEC_W-1:0]     intVector
);

  localparam int NUM_WORDS = (NUM_LINES + (DATA_W / 8) - 1) / (DATA_W / 8);

  strobes_t             strb;
  logic                 winValid;
  logic [IDX_W-1:0]     winIdx;
  logic [NUM_LINES-1:0] enVec;
  logic [NUM_LINES-1:0] pendVec;

  intc_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NUM_WORDS)
  ) uCtrl (
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  intc_datapath #(
    .NUM_LINES(NUM_LINES),
    .PRIO_BITS(PRIO_BITS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWdata),
    .irqLines(irqLines),
    .intAck  (intAck),
    .rdData  (busRdata),
    .winValid(winValid),
    .winIdx  (winIdx),
    .enQ     (enVec),
    .pendQ   (pendVec)
  );

  assign intValid  = winValid;
  assign intVector = winValid ? VEC_W'(VEC_BASE) + VEC_W'(winIdx) : '0;

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int VEC_BASE  = 16,
  parameter int IDX_W     = $clog2(NUM_LINES),
  parameter int VEC_W     = $clog2(VEC_BASE + NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWr,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic [NUM_LINES-1:0] irqLines,
  input logic                 intAck,
  input logic                 intValid,
  input logic [VEC_W-1:0]     intVector,
  input logic [NUM_LINES-1:0] enVec,
  input logic [NUM_LINES-1:0] pendVec
);

  logic [IDX_W-1:0] winLine;
  assign winLine = IDX_W'(intVector - VEC_W'(VEC_BASE));

  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    intValid |-> (intVector >= VEC_W'(VEC_BASE)) && (int'(intVector) < VEC_BASE + NUM_LINES)); // R9
  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    !intValid |-> intVector == '0); // R9
  AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    intValid |-> pendVec[winLine] && enVec[winLine]); // R12
  AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & enVec) == '0) |-> !intValid); // R12

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == ADDR_W'(12'h100) && busWdata[g]) |=> enVec[g]); // R2
    AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == ADDR_W'(12'h180) && busWdata[g]) |=> !enVec[g]); // R3
    AST_EDGE_PEND: assert property (@(posedge clk) disable iff (!rstN)
      (!irqLines[g] ##1 irqLines[g]) |=> pendVec[g]); // R6
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (intAck && intValid && winLine == IDX_W'(g) && !busWr && !irqLines[g]) |=> !pendVec[g]); // R10
  end

endmodule

bind intc_top intc_checker #(
  .NUM_LINES(NUM_LINES),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .VEC_BASE (VEC_BASE),
  .IDX_W    (IDX_W),
  .VEC_W    (VEC_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .irqLines (irqLines),
  .intAck   (intAck),
  .intValid (intValid),
  .intVector(intVector),
  .enVec    (enVec),
  .pendVec  (pendVec)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;

  localparam logic [11:0] A_ESET = 12'h100;
  localparam logic [11:0] A_ECLR = 12'h180;
  localparam logic [11:0] A_PSET = 12'h200;
  localparam logic [11:0] A_PCLR = 12'h280;
  localparam logic [11:0] A_PRI0 = 12'h400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] irqLines = '0;
  logic        intAck = 1'b0;
  logic        intValid;
  logic [4:0]  intVector;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curTag = "R1";

  // Reference state
  bit [15:0] mEn, mPend, mPrev;
  int        mPrio [16];

  always #4 clk = ~clk;

  intc_top dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqLines(irqLines),
    .intAck(intAck), .intValid(intValid), .intVector(intVector)
  );

  function automatic int modelWinner();
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 16; l++)
        if (mEn[l] && mPend[l] && mPrio[l] == p) return l;
    return -1;
  endfunction

  function automatic logic [31:0] modelRead(logic [11:0] a);
    logic [31:0] r = '0;
    if (a == A_ESET || a == A_ECLR) r = {16'h0, mEn};
    else if (a == A_PSET || a == A_PCLR) r = {16'h0, mPend};
    else if (a >= A_PRI0 && a <= A_PRI0 + 12 && a[1:0] == 2'b00)
      for (int j = 0; j < 4; j++) r[8*j+6 +: 2] = 2'(mPrio[(a - A_PRI0) + j]);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = '0; mPend = '0; mPrev = '0;
      for (int l = 0; l < 16; l++) mPrio[l] = 0;
    end else begin
      int w;
      w = modelWinner();
      if (intAck && w >= 0) mPend[w] = 1'b0;
      if (busWr) begin
        case (busAddr)
          A_ESET: mEn = mEn | busWdata[15:0];
          A_ECLR: mEn = mEn & ~busWdata[15:0];
          A_PSET: mPend = mPend | busWdata[15:0];
          A_PCLR: mPend = mPend & ~busWdata[15:0];
          default: begin
            for (int k = 0; k < 4; k++)
              if (busAddr == A_PRI0 + 12'(4*k))
                for (int j = 0; j < 4; j++) mPrio[4*k+j] = int'(busWdata[8*j+6 +: 2]);
          end
        endcase
      end
      mPend = mPend | (irqLines & ~mPrev);
      mPrev = irqLines;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int w;
    w = modelWinner();
    check(curTag, {31'h0, intValid}, {31'h0, w >= 0}, "valid");
    check(curTag, {27'h0, intVector}, (w >= 0) ? 32'(w + 16) : 32'h0, "vector");
    check(curTag, busRdata, modelRead(busAddr), "read data");
  endtask

  task automatic tick(string tag);
    curTag = tag;
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    busWr = 1'b1; busAddr = a; busWdata = d;
    tick(tag);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    busAddr = a;
    #1;
    check(tag, busRdata, exp, "readback");
  endtask

  task automatic expectVec(bit v, int vec, string tag);
    check(tag, {31'h0, intValid}, {31'h0, v}, "valid");
    check(tag, {27'h0, intVector}, 32'(vec), "vector");
  endtask

  initial begin
    bit [15:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(A_ESET, 0, "R1"); rd(A_PSET, 0, "R1"); rd(A_PRI0, 0, "R1"); rd(A_PRI0 + 12, 0, "R1");
    expectVec(0, 0, "R1");
    // R2 set-enable, both addresses read it
    wr(A_ESET, 32'h0000_00F0, "R2");
    rd(A_ESET, 32'h00F0, "R2"); rd(A_ECLR, 32'h00F0, "R2");
    wr(A_ESET, 32'h0, "R2"); rd(A_ESET, 32'h00F0, "R2");
    // R3 clear-enable
    wr(A_ECLR, 32'h0000_0030, "R3"); rd(A_ECLR, 32'h00C0, "R3");
    wr(A_ECLR, 32'h0, "R3"); rd(A_ESET, 32'h00C0, "R3");
    // R5 priority fields
    wr(A_PRI0, 32'hFFFF_FFFF, "R5"); rd(A_PRI0, 32'hC0C0_C0C0, "R5");
    wr(A_PRI0 + 4, 32'h3F3F_3F3F, "R5"); rd(A_PRI0 + 4, 32'h0, "R5");
    wr(A_PRI0 + 8, 32'h4000_0080, "R5"); rd(A_PRI0 + 8, 32'h4000_0080, "R5");
    wr(A_PRI0 + 8, 32'h0, "R5");
    // R4 software pending
    wr(A_PSET, 32'h0000_0005, "R4"); rd(A_PSET, 32'h5, "R4"); rd(A_PCLR, 32'h5, "R4");
    wr(A_PCLR, 32'h0000_0001, "R4"); rd(A_PSET, 32'h4, "R4");
    wr(A_PCLR, 32'h0, "R4"); rd(A_PCLR, 32'h4, "R4");
    // R12 pending but disabled line 2 not presented, then enabled
    expectVec(0, 0, "R12");
    wr(A_ESET, 32'h0000_0004, "R12"); expectVec(1, 18, "R12");
    // R7 line 6 (priority 0) beats line 2 (priority 3)
    wr(A_PSET, 32'h0000_0040, "R7"); expectVec(1, 22, "R7");
    // R8 line 7 same priority as line 6: lower line wins
    wr(A_PSET, 32'h0000_0080, "R8"); expectVec(1, 22, "R8");
    // R10 acknowledges step through winners
    intAck = 1'b1; tick("R10"); intAck = 1'b0; expectVec(1, 23, "R10");
    intAck = 1'b1; tick("R10"); intAck = 1'b0; expectVec(1, 18, "R10");
    intAck = 1'b1; tick("R10"); intAck = 1'b0; expectVec(0, 0, "R9");
    rd(A_PSET, 32'h0, "R10");
    // R6 edge-sensitive request on line 5
    wr(A_ESET, 32'h0000_0020, "R6");
    irqLines[5] = 1'b1; tick("R6"); expectVec(1, 21, "R6");
    intAck = 1'b1; tick("R6"); intAck = 1'b0;
    tick("R6"); tick("R6"); expectVec(0, 0, "R6");
    // R11 edge beats clear-pending write and ack on the same edge
    irqLines[5] = 1'b0; tick("R11");
    irqLines[5] = 1'b1; wr(A_PCLR, 32'h0000_0020, "R11"); rd(A_PSET, 32'h20, "R11");
    irqLines[5] = 1'b0; tick("R11");
    irqLines[5] = 1'b1; intAck = 1'b1; tick("R11"); intAck = 1'b0;
    expectVec(1, 21, "R11");
    // R13 unmapped address
    wr(12'h104, 32'hFFFF_FFFF, "R13"); rd(12'h104, 32'h0, "R13");
    rd(A_ESET, 32'h00E4, "R13"); rd(A_PRI0 + 4, 32'h0, "R13");
    // Mixed pseudo-random traffic against the model
    lfsr = 16'hACE1;
    irqLines = '0;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      busWr = lfsr[0] & lfsr[5];
      case (lfsr[3:1])
        3'd0: busAddr = A_ESET;
        3'd1: busAddr = A_ECLR;
        3'd2: busAddr = A_PSET;
        3'd3: busAddr = A_PCLR;
        3'd4: busAddr = A_PRI0 + 12'(4 * lfsr[9:8]);
        3'd5: busAddr = A_PRI0 + 12'(4 * lfsr[11:10]);
        3'd6: busAddr = 12'h300;
        default: busAddr = A_ESET;
      endcase
      busWdata = {lfsr, lfsr[7:0], lfsr[15:8]} & {16'hFFFF, lfsr[4] ? 16'h00FF : 16'hFF00};
      irqLines = irqLines ^ (16'(1) << lfsr[15:12]) & {16{lfsr[6]}};
      intAck = lfsr[7] & lfsr[2];
      tick("R7");
    end
    busWr = 1'b0; intAck = 1'b0;
    tick("R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule